// File: doc/BRIEF.md
# Shadow RAM store/recall guard controller

This controller sequences transfers between a shadow RAM and the nonvolatile array behind it. When supply power is reported good, it first runs an automatic recall that copies the nonvolatile contents into RAM. While that recall runs, the controller reports busy and discards every request. After that it accepts recall and store requests. Each request can come from a decoded software command or from an active-low hardware pin. A hardware request is recognised on the falling edge of its pin.

Stores are guarded twice. A write-enable latch is set and cleared by software commands. A previous-recall latch is set only by an explicit recall after power-up; the automatic power-up recall does not set it. A store starts only when both latches are set and the chip-enable, recall pin and store pin levels allow it. A refused store request is dropped without a trace. An accepted store emits a one-cycle strobe and holds busy for a configurable number of cycles, and a visible timer counts those cycles down. Recall requests that arrive during a store are dropped. Losing power good at any time aborts all activity and clears both latches.

Top module: `shadow_xfer_ctrl`

## Requirements
- R1: While `pwrGood` is low, the following hold from the next clock edge on: `busy` is 1, `recallStart` and `storeStart` are 0, `storeTimer` is 0, and both latches are cleared.
- R2: On the first clock edge that sees `pwrGood` high after it was low, `recallStart` pulses for one cycle. `busy` then stays 1 for exactly PUR_CYCLES cycles and then drops to 0.
- R3: While the power-up recall runs, every command and pin request is ignored. A recall issued then produces no `recallStart` and does not set the previous-recall latch, and a write-enable issued then does not set the write-enable latch.
- R4: The power-up recall leaves the previous-recall latch cleared. A write-enable followed by a store request, with no explicit recall, produces no store.
- R5: When idle, an explicit recall request (`cmdRecall` high, or a falling edge on `recallPinN`) makes `recallStart` pulse for one cycle after the request cycle and sets the previous-recall latch. `busy` stays 0.
- R6: `cmdWren` sets the write-enable latch and `cmdWrds` clears it. When both are high in the same cycle, the latch is cleared.
- R7: A store request (`cmdStore` high, or a falling edge on `storePinN`) starts a store only if, in the request cycle, all of the following hold: both latches are set, `chipEn` is 1, `recallPinN` is 1 and `storePinN` is 0. Any other store request is discarded and never performed later.
- R8: An accepted store pulses `storeStart` for one cycle and holds `busy` at 1 for STORE_CYCLES cycles. In its first cycle `storeTimer` equals STORE_CYCLES. It then falls by one each cycle and reaches 0 as `busy` drops. `storeTimer` is 0 outside a store.
- R9: A recall request made while a store is in progress is discarded. It produces no `recallStart`, either during the store or after it.
- R10: When a recall request and a store request arrive in the same idle cycle, the recall is performed and the store is discarded.
- R11: Dropping `pwrGood` during a store aborts it: `busy` stays 1 and `storeTimer` becomes 0. After the next power-up, a store is refused until a new write-enable and a new explicit recall have been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supply good indication; low forces the powered-down state |
| cmdWren | input | 1 | Decoded write-enable command, one cycle |
| cmdWrds | input | 1 | Decoded write-disable command, one cycle |
| cmdRecall | input | 1 | Decoded recall command, one cycle |
| cmdStore | input | 1 | Decoded store command, one cycle |
| chipEn | input | 1 | Chip enable level; low blocks stores |
| recallPinN | input | 1 | Active-low recall pin; falling edge requests recall, low level blocks stores |
| storePinN | input | 1 | Active-low store pin; falling edge requests store, high level blocks stores |
| busy | output | 1 | High while powered down, during power-up recall and during a store |
| recallStart | output | 1 | One-cycle strobe starting a recall |
| storeStart | output | 1 | One-cycle strobe starting a store |
| storeTimer | output | CNT_W | Remaining store cycles, 0 when no store runs |

## Verification
The store gate is driven by a table of latch and pin combinations. Each row clears exactly one enabling condition, so every discarded store can be traced to the single input that blocked it. Directed sequences separate the power-up recall from an explicit recall: a write-enable and store after power-up alone must fail, and the same store must succeed after one recall. Further sequences cover simultaneous write-enable and write-disable, simultaneous recall and store, recall attempts during a store, and commands issued inside the power-up window. Both pin edges are tested as hardware requests, and a power loss mid-store is shown to leave both latches cleared.

// File: rtl/shadow_xfer_pkg.sv
package shadow_xfer_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PUR   = 2'd1,
    ST_IDLE  = 2'd2,
    ST_STORE = 2'd3
  } xferState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clrAll;
    logic loadPur;
    logic loadStore;
    logic countDown;
    logic setWe;
    logic clrWe;
    logic setPr;
    logic fireRecall;
    logic fireStore;
  } xferCtl_t;

endpackage

// File: rtl/shadow_xfer_fsm.sv
module shadow_xfer_fsm
  import shadow_xfer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pwrGood,
  input  logic     cmdWren,
  input  logic     cmdWrds,
  input  logic     cmdRecall,
  input  logic     cmdStore,
  input  logic     chipEn,
  input  logic     recallPinN,
  input  logic     storePinN,
  input  logic     recallFall,
  input  logic     storeFall,
  input  logic     weLatch,
  input  logic     prLatch,
  input  logic     countLast,
  output xferCtl_t ctl,
  output logic     inStore,
  output logic     busy
);

  xferState_t state, nextState;
  logic recallReq, storeReq, storeOk;

  assign recallReq = cmdRecall | recallFall;
  assign storeReq  = cmdStore | storeFall;
  assign storeOk   = weLatch & prLatch & chipEn & recallPinN & ~storePinN;

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (!pwrGood) begin
      ctl.clrAll = 1'b1;
      nextState  = ST_OFF;
    end else begin
      case (state)
        ST_OFF: begin
          ctl.loadPur    = 1'b1;
          ctl.fireRecall = 1'b1;
          nextState      = ST_PUR;
        end
        ST_PUR: begin
          ctl.countDown = 1'b1;
          if (countLast) nextState = ST_IDLE;
        end
        ST_IDLE: begin
          if (cmdWrds)      ctl.clrWe = 1'b1;
          else if (cmdWren) ctl.setWe = 1'b1;
          if (recallReq) begin
            ctl.fireRecall = 1'b1;
            ctl.setPr      = 1'b1;
          end else if (storeReq && storeOk) begin
            ctl.loadStore = 1'b1;
            ctl.fireStore = 1'b1;
            nextState     = ST_STORE;
          end
        end
        ST_STORE: begin
          if (cmdWrds)      ctl.clrWe = 1'b1;
          else if (cmdWren) ctl.setWe = 1'b1;
          ctl.countDown = 1'b1;
          if (countLast) nextState = ST_IDLE;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  assign inStore = (state == ST_STORE);
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/shadow_xfer_dp.sv
module shadow_xfer_dp
  import shadow_xfer_pkg::*;
#(
  parameter int PUR_CYCLES   = 1000,
  parameter int STORE_CYCLES = 250000,
  parameter int CNT_W        = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  xferCtl_t         ctl,
  input  logic             inStore,
  input  logic             recallPinN,
  input  logic             storePinN,
  output logic             recallFall,
  output logic             storeFall,
  output logic             weLatch,
  output logic             prLatch,
  output logic             countLast,
  output logic             recallStart,
  output logic             storeStart,
  output logic [CNT_W-1:0] storeTimer
);

  localparam logic [CNT_W-1:0] PUR_LOAD   = CNT_W'(PUR_CYCLES);
  localparam logic [CNT_W-1:0] STORE_LOAD = CNT_W'(STORE_CYCLES);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic recallPrev, storePrev;

  // pin edge detection, idle level of both registers is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recallPrev <= 1'b1;
      storePrev  <= 1'b1;
    end else begin
      recallPrev <= recallPinN;
      storePrev  <= storePinN;
    end
  end

  assign recallFall = recallPrev & ~recallPinN;
  assign storeFall  = storePrev & ~storePinN;

  // shared down-counter for power-up recall and store duration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           count <= '0;
    else if (ctl.clrAll)                 count <= '0;
    else if (ctl.loadPur)                count <= PUR_LOAD;
    else if (ctl.loadStore)              count <= STORE_LOAD;
    else if (ctl.countDown && count != 0) count <= count - ONE;
  end

  assign countLast  = (count == ONE);
  assign storeTimer = inStore ? count : '0;

  // protection latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLatch <= 1'b0;
      prLatch <= 1'b0;
    end else if (ctl.clrAll) begin
      weLatch <= 1'b0;
      prLatch <= 1'b0;
    end else begin
      if (ctl.clrWe)      weLatch <= 1'b0;
      else if (ctl.setWe) weLatch <= 1'b1;
      if (ctl.setPr)      prLatch <= 1'b1;
    end
  end

  // registered start strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recallStart <= 1'b0;
      storeStart  <= 1'b0;
    end else begin
      recallStart <= ctl.fireRecall;
      storeStart  <= ctl.fireStore;
    end
  end

endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
  import shadow_xfer_pkg::*;
#(
  parameter int PUR_CYCLES   = 1000,
  parameter int STORE_CYCLES = 250000,
  localparam int MAX_CNT     = (PUR_CYCLES > STORE_CYCLES) ? PUR_CYCLES : STORE_CYCLES,
  localparam int CNT_W       = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrGood,
  input  logic             cmdWren,
  input  logic             cmdWrds,
  input  logic             cmdRecall,
  input  logic             cmdStore,
  input  logic             chipEn,
  input  logic             recallPinN,
  input  logic             storePinN,
  output logic             busy,
  output logic             recallStart,
  output logic             storeStart,
  output logic [CNT_W-1:0] storeTimer
);

  xferCtl_t ctl;
  logic recallFall, storeFall, weLatch, prLatch, countLast, inStore;

  shadow_xfer_fsm u_fsm (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood),
    .cmdWren(cmdWren), .cmdWrds(cmdWrds), .cmdRecall(cmdRecall), .cmdStore(cmdStore),
    .chipEn(chipEn), .recallPinN(recallPinN), .storePinN(storePinN),
    .recallFall(recallFall), .storeFall(storeFall),
    .weLatch(weLatch), .prLatch(prLatch), .countLast(countLast),
    .ctl(ctl), .inStore(inStore), .busy(busy)
  );

  shadow_xfer_dp #(
    .PUR_CYCLES(PUR_CYCLES), .STORE_CYCLES(STORE_CYCLES), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inStore(inStore),
    .recallPinN(recallPinN), .storePinN(storePinN),
    .recallFall(recallFall), .storeFall(storeFall),
    .weLatch(weLatch), .prLatch(prLatch), .countLast(countLast),
    .recallStart(recallStart), .storeStart(storeStart), .storeTimer(storeTimer)
  );

endmodule

// File: rtl/shadow_xfer_chk.sv
module shadow_xfer_chk #(
  parameter int CNT_W        = 18,
  parameter int STORE_CYCLES = 250000
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrGood,
  input logic             chipEn,
  input logic             recallPinN,
  input logic             storePinN,
  input logic             busy,
  input logic             recallStart,
  input logic             storeStart,
  input logic [CNT_W-1:0] storeTimer,
  input logic             weLatch,
  input logic             prLatch
);

  AST_OFF_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> busy && !storeStart && storeTimer == 0 && !weLatch && !prLatch); // R1

  AST_GATE_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> $past(weLatch && prLatch)); // R7

  AST_GATE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> $past(chipEn && recallPinN && !storePinN)); // R7

  AST_STORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> busy && storeTimer == CNT_W'(STORE_CYCLES)); // R8

  AST_STORE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && storeTimer > 1) |=> storeTimer == $past(storeTimer) - CNT_W'(1)); // R8

  AST_NO_RECALL_IN_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && storeTimer != 0) |=> !recallStart); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(recallStart && storeStart)); // R10

  AST_PR_BY_RECALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prLatch) |-> recallStart && !busy); // R5

endmodule

bind shadow_xfer_ctrl shadow_xfer_chk #(.CNT_W(CNT_W), .STORE_CYCLES(STORE_CYCLES)) u_chk (.*);

// File: tb/shadow_xfer_ctrl_tb.sv
module shadow_xfer_ctrl_tb;

  localparam int PUR   = 6;
  localparam int STORE = 10;
  localparam int CW    = $clog2(((PUR > STORE) ? PUR : STORE) + 1);

  logic clk = 1'b0;
  logic rstN, pwrGood, cmdWren, cmdWrds, cmdRecall, cmdStore;
  logic chipEn, recallPinN, storePinN;
  logic busy, recallStart, storeStart;
  logic [CW-1:0] storeTimer;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  shadow_xfer_ctrl #(.PUR_CYCLES(PUR), .STORE_CYCLES(STORE)) u_dut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood),
    .cmdWren(cmdWren), .cmdWrds(cmdWrds), .cmdRecall(cmdRecall), .cmdStore(cmdStore),
    .chipEn(chipEn), .recallPinN(recallPinN), .storePinN(storePinN),
    .busy(busy), .recallStart(recallStart), .storeStart(storeStart), .storeTimer(storeTimer)
  );

  // store gate table: {we, pr, chipEn, recallPinN, storePinN, expectStore}
  localparam logic [5:0] GATE_TAB [6] = '{
    6'b11_1_1_0_1,
    6'b01_1_1_0_0,
    6'b10_1_1_0_0,
    6'b11_0_1_0_0,
    6'b11_1_0_0_0,
    6'b11_1_1_1_0
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // mask bits: 3 wren, 2 wrds, 1 recall, 0 store
  task automatic cmdPulse(input logic [3:0] m);
    {cmdWren, cmdWrds, cmdRecall, cmdStore} = m;
    tick();
    {cmdWren, cmdWrds, cmdRecall, cmdStore} = 4'b0;
  endtask

  task automatic waitIdle();
    while (busy) tick();
  endtask

  task automatic powerDown();
    pwrGood = 1'b0;
    chipEn = 1'b1;
    recallPinN = 1'b1;
    storePinN = 1'b0;
    repeat (2) tick();
  endtask

  task automatic powerCycle();
    int n;
    powerDown();
    pwrGood = 1'b1;
    tick();
    chk("R2 power-up recall strobe", recallStart, 1);
    n = 0;
    while (busy && n < 100) begin
      n++;
      tick();
    end
    chk("R2 power-up busy length", n, PUR);
    chk("R2 strobe single cycle", recallStart, 0);
  endtask

  task automatic runStore(input string tag);
    chk({tag, " storeStart"}, storeStart, 1);
    chk({tag, " timer load"}, storeTimer, STORE);
    for (int i = 2; i <= STORE + 1; i++) begin
      cmdRecall = (i == 3);
      tick();
      cmdRecall = 1'b0;
      chk({tag, " timer"}, storeTimer, STORE - i + 1);
      chk({tag, " busy"}, busy, (i <= STORE) ? 1 : 0);
      chk("R9 no recall during store", recallStart, 0);
    end
    tick();
    chk("R9 recall not deferred", recallStart, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    pwrGood = 1'b0;
    {cmdWren, cmdWrds, cmdRecall, cmdStore} = 4'b0;
    chipEn = 1'b1;
    recallPinN = 1'b1;
    storePinN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    repeat (2) tick();
    chk("R1 busy while power down", busy, 1);
    chk("R1 no recall strobe", recallStart, 0);
    chk("R1 no store strobe", storeStart, 0);
    chk("R1 timer zero", storeTimer, 0);

    // R2 and R4: power-up recall alone does not permit a store
    powerCycle();
    cmdPulse(4'b1000);
    cmdPulse(4'b0001);
    chk("R4 store refused without recall", storeStart, 0);
    tick();
    chk("R4 not busy", busy, 0);

    // R5 explicit recall, then R8/R9 store
    cmdPulse(4'b0010);
    chk("R5 recall strobe", recallStart, 1);
    chk("R5 busy stays low", busy, 0);
    tick();
    chk("R5 strobe one cycle", recallStart, 0);
    chk("R8 timer zero when idle", storeTimer, 0);
    cmdPulse(4'b0001);
    runStore("R8");

    // R6: simultaneous wren and wrds clears
    cmdPulse(4'b1100);
    cmdPulse(4'b0001);
    chk("R6 both commands clear latch", storeStart, 0);
    cmdPulse(4'b1000);
    cmdPulse(4'b0100);
    cmdPulse(4'b0001);
    chk("R6 wrds clears latch", storeStart, 0);
    cmdPulse(4'b1000);
    cmdPulse(4'b0001);
    chk("R6 wren sets latch", storeStart, 1);
    waitIdle();

    // R10: recall and store together
    cmdPulse(4'b0011);
    chk("R10 recall wins", recallStart, 1);
    chk("R10 store dropped", storeStart, 0);
    tick();
    chk("R10 not busy", busy, 0);

    // R7 hardware store request on store pin falling edge
    storePinN = 1'b1;
    tick();
    storePinN = 1'b0;
    tick();
    chk("R7 pin store accepted", storeStart, 1);
    waitIdle();

    // R5 hardware recall on recall pin falling edge
    recallPinN = 1'b0;
    tick();
    chk("R5 pin recall strobe", recallStart, 1);
    recallPinN = 1'b1;
    tick();

    // R7 gate table
    for (int r = 0; r < 6; r++) begin
      logic [5:0] v;
      v = GATE_TAB[r];
      powerCycle();
      if (v[4]) cmdPulse(4'b0010);
      if (v[5]) cmdPulse(4'b1000);
      chipEn = v[3];
      recallPinN = v[2];
      storePinN = v[1];
      repeat (2) tick();
      cmdPulse(4'b0001);
      chk($sformatf("R7 gate row %0d storeStart", r), storeStart, v[0]);
      tick();
      chk($sformatf("R7 gate row %0d busy", r), busy, v[0]);
      waitIdle();
      tick();
      chk($sformatf("R7 gate row %0d no late store", r), storeStart, 0);
    end

    // R3: commands during power-up recall are ignored
    powerDown();
    pwrGood = 1'b1;
    tick();
    tick();
    cmdPulse(4'b1010);
    chk("R3 recall ignored in power-up", recallStart, 0);
    waitIdle();
    cmdPulse(4'b0001);
    chk("R3 previous-recall not set", storeStart, 0);
    cmdPulse(4'b0010);
    cmdPulse(4'b0001);
    chk("R3 write-enable not set", storeStart, 0);

    // R11: power loss mid-store
    cmdPulse(4'b1000);
    cmdPulse(4'b0001);
    chk("R11 store started", storeStart, 1);
    repeat (3) tick();
    pwrGood = 1'b0;
    tick();
    tick();
    chk("R11 busy after abort", busy, 1);
    chk("R11 timer cleared", storeTimer, 0);
    chk("R1 no store strobe when off", storeStart, 0);
    powerCycle();
    cmdPulse(4'b0010);
    cmdPulse(4'b0001);
    chk("R11 write-enable cleared by power loss", storeStart, 0);
    powerCycle();
    cmdPulse(4'b1000);
    cmdPulse(4'b0001);
    chk("R11 previous-recall cleared by power loss", storeStart, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule